// File: doc/BRIEF.md
# NAND Flash Byte Transfer Sequencer

This block turns single-byte transfer descriptors into correctly timed strobe sequences on an 8-bit NAND flash pin set. Each descriptor carries a two-bit kind (command, address, write data or read data) and, for the three write-type kinds, one byte. The sequencer asserts chip enable for the whole transfer. It raises the command latch or the address latch as the kind requires, and pulses the write or read strobe. It then returns read bytes on a one-cycle valid pulse.

All timing comes from static configuration inputs, counted in clock cycles. The inputs set how long the data pins stay undriven at the start of a write, the setup time before the strobe falls, the minimum strobe low width, and the hold time after the strobe rises. They also set two separate minimum delays before a read strobe: one measured from the command latch falling, one from the address latch falling. When ready/busy waiting is enabled, a new transfer is held off while the device reports busy. The bidirectional data pins are presented as a separate output, output enable and input, so the pad ring can build the tri-state buffer.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), the command and address latches are low, the output enable is low, read valid is low, and the request port is ready.
- R2: Kind code 0 is a command and raises the command latch, code 1 is an address and raises the address latch, code 2 writes a data byte and code 3 reads a data byte; both data kinds raise neither latch. Chip enable is low from the start to the end of every transfer, and high for at least one cycle between transfers.
- R3: On kinds 0, 1 and 2, the output enable stays low for exactly `cfgHiz` cycles after chip enable falls, and only then rises.
- R4: On a write-type transfer, the write strobe falls exactly `cfgSetup` cycles after the output enable rises. On a read, the read strobe falls no sooner than `cfgSetup`+1 cycles after chip enable falls.
- R5: The active strobe stays low for `cfgStrobe` cycles, or for 1 cycle when `cfgStrobe` is 0. The read and write strobes are never low together.
- R6: Chip enable and the latches rise and fall respectively exactly `cfgHold` cycles after the strobe rises. On write-type transfers the output enable falls in that same cycle.
- R7: A read strobe falls at least `cfgCleRe` cycles after the most recent fall of the command latch, and at least `cfgAleRe` cycles after the most recent fall of the address latch.
- R8: A read samples `ioIn` on the clock edge that raises the read strobe. On that same edge `rdValid` goes high for one cycle with the sampled byte on `rdByte`. The output enable stays low for the whole read.
- R9: With `cfgWaitEn` high and `rbN` low, no request is accepted and chip enable stays high. With `cfgWaitEn` low, `rbN` has no effect.
- R10: On write-type transfers, `ioOut` carries the descriptor byte and stays unchanged while the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Descriptor offered |
| reqReady | output | 1 | Descriptor accepted when high together with reqValid |
| reqKind | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| reqByte | input | 8 | Byte for kinds 0 to 2 |
| rdValid | output | 1 | One-cycle pulse with a read byte |
| rdByte | output | 8 | Byte returned by a read |
| cfgHiz | input | 8 | Undriven cycles before a write drives the pins |
| cfgSetup | input | 8 | Setup cycles before the strobe |
| cfgStrobe | input | 8 | Strobe low width (0 acts as 1) |
| cfgHold | input | 8 | Hold cycles after the strobe |
| cfgCleRe | input | 8 | Minimum command-latch-low to read-strobe-low delay |
| cfgAleRe | input | 8 | Minimum address-latch-low to read-strobe-low delay |
| cfgWaitEn | input | 1 | Hold off new transfers while the device is busy |
| rbN | input | 1 | Device ready (high) / busy (low) |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| ioOut | output | 8 | Byte driven to the data pins |
| ioOe | output | 1 | Drive enable for the data pins |
| ioIn | input | 8 | Byte read from the data pins |

## Verification
When the hold time is zero, three things happen on the same clock edge: the read strobe rises, the read byte is captured, and chip enable is released. The bench provokes this with directed reads at zero hold and again in random rounds where the hold draws zero. It judges the edge by requiring, at that very edge, a valid pulse carrying the device byte, and an end-of-transfer time equal to the strobe-rise time. A second collision is a request offered while ready/busy waiting is active. There the bench checks that chip enable stays high for the whole busy window, and that the transfer then runs normally.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [1:0] KIND_CMD   = 2'd0;
  localparam logic [1:0] KIND_ADDR  = 2'd1;
  localparam logic [1:0] KIND_WDATA = 2'd2;
  localparam logic [1:0] KIND_RDATA = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_GAP    = 3'd1,
    PH_HIZ    = 3'd2,
    PH_SETUP  = 3'd3,
    PH_STROBE = 3'd4,
    PH_HOLD   = 3'd5
  } phase_e;

  // control-to-datapath strobes for one cycle
  typedef struct packed {
    logic ceOn;
    logic cleOn;
    logic aleOn;
    logic weOn;
    logic reOn;
    logic drive;
    logic take;
  } strobe_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  output logic             reqReady,
  input  logic             rbReady,
  input  logic [CNT_W-1:0] cfgHiz,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgStrobe,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgCleRe,
  input  logic [CNT_W-1:0] cfgAleRe,
  input  logic             cfgWaitEn,
  output strobe_t          st
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  phase_e           state, nxt, afterPre, afterStrobe;
  logic [CNT_W-1:0] cnt, nxtLen, strobeLen;
  logic [CNT_W-1:0] cleGap, aleGap;
  logic [1:0]       kindQ;
  logic             accept, gapsMet;

  assign reqReady = (state == PH_IDLE) && (!cfgWaitEn || rbReady);
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobeLen   = (cfgStrobe == '0) ? CNT_ONE : cfgStrobe;
    afterPre    = (cfgSetup != '0) ? PH_SETUP : PH_STROBE;
    afterStrobe = (cfgHold != '0) ? PH_HOLD : PH_IDLE;
    gapsMet     = (cleGap >= cfgCleRe) && (aleGap >= cfgAleRe);
    nxt = state;
    unique case (state)
      PH_IDLE: begin
        if (accept) begin
          if (reqKind == KIND_RDATA)  nxt = PH_GAP;
          else if (cfgHiz != '0)      nxt = PH_HIZ;
          else                        nxt = afterPre;
        end
      end
      PH_GAP:    if (gapsMet)    nxt = afterPre;
      PH_HIZ:    if (cnt == '0)  nxt = afterPre;
      PH_SETUP:  if (cnt == '0)  nxt = PH_STROBE;
      PH_STROBE: if (cnt == '0)  nxt = afterStrobe;
      PH_HOLD:   if (cnt == '0)  nxt = PH_IDLE;
      default:                   nxt = PH_IDLE;
    endcase
    case (nxt)
      PH_HIZ:    nxtLen = cfgHiz;
      PH_SETUP:  nxtLen = cfgSetup;
      PH_STROBE: nxtLen = strobeLen;
      PH_HOLD:   nxtLen = cfgHold;
      default:   nxtLen = CNT_ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PH_IDLE;
      cnt   <= '0;
      kindQ <= KIND_CMD;
    end else begin
      state <= nxt;
      if (nxt != state)    cnt <= nxtLen - CNT_ONE;
      else if (cnt != '0)  cnt <= cnt - CNT_ONE;
      if (accept)          kindQ <= reqKind;
    end
  end

  // strobe decode from the registered phase
  always_comb begin
    st.ceOn  = (state != PH_IDLE);
    st.cleOn = st.ceOn && (kindQ == KIND_CMD);
    st.aleOn = st.ceOn && (kindQ == KIND_ADDR);
    st.weOn  = (state == PH_STROBE) && (kindQ != KIND_RDATA);
    st.reOn  = (state == PH_STROBE) && (kindQ == KIND_RDATA);
    st.drive = st.ceOn && (kindQ != KIND_RDATA) && (state != PH_HIZ);
    st.take  = accept;
  end

  // cycles since each latch was last high, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      cleGap <= CNT_MAX;
      aleGap <= CNT_MAX;
    end else begin
      if (st.cleOn)              cleGap <= '0;
      else if (cleGap != CNT_MAX) cleGap <= cleGap + CNT_ONE;
      if (st.aleOn)              aleGap <= '0;
      else if (aleGap != CNT_MAX) aleGap <= aleGap + CNT_ONE;
    end
  end

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] reqByte,
  input  logic [DATA_W-1:0] ioIn,
  input  logic              rbN,
  output logic              rbReady,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] ioOut,
  output logic              ioOe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdByte
);

  logic [SYNC_N-1:0] rbSync;

  always_ff @(posedge clk) begin
    if (rst) rbSync <= '1;
    else     rbSync <= {rbSync[SYNC_N-2:0], rbN};
  end
  assign rbReady = rbSync[SYNC_N-1];

  // registered pins: one cycle behind the control phase
  always_ff @(posedge clk) begin
    if (rst) begin
      nandCeN <= 1'b1;
      nandCle <= 1'b0;
      nandAle <= 1'b0;
      nandWeN <= 1'b1;
      nandReN <= 1'b1;
      ioOe    <= 1'b0;
    end else begin
      nandCeN <= !st.ceOn;
      nandCle <= st.cleOn;
      nandAle <= st.aleOn;
      nandWeN <= !st.weOn;
      nandReN <= !st.reOn;
      ioOe    <= st.drive;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ioOut <= '0;
    else if (st.take) ioOut <= reqByte;
  end

  // capture on the edge that releases the read strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rdValid <= 1'b0;
      rdByte  <= '0;
    end else begin
      rdValid <= !nandReN && !st.reOn;
      if (!nandReN && !st.reOn) rdByte <= ioIn;
    end
  end

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqByte,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdByte,
  input  logic [CNT_W-1:0]  cfgHiz,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgStrobe,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  cfgCleRe,
  input  logic [CNT_W-1:0]  cfgAleRe,
  input  logic              cfgWaitEn,
  input  logic              rbN,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [DATA_W-1:0] ioOut,
  output logic              ioOe,
  input  logic [DATA_W-1:0] ioIn
);

  strobe_t st;
  logic    rbReady;

  nand_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqKind(reqKind),
    .reqReady(reqReady), .rbReady(rbReady),
    .cfgHiz(cfgHiz), .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe),
    .cfgHold(cfgHold), .cfgCleRe(cfgCleRe), .cfgAleRe(cfgAleRe),
    .cfgWaitEn(cfgWaitEn), .st(st)
  );

  nand_seq_dp #(.DATA_W(DATA_W), .SYNC_N(2)) u_dp (
    .clk(clk), .rst(rst), .st(st), .reqByte(reqByte), .ioIn(ioIn),
    .rbN(rbN), .rbReady(rbReady),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN),
    .ioOut(ioOut), .ioOe(ioOe), .rdValid(rdValid), .rdByte(rdByte)
  );

endmodule

// File: rtl/nand_strobe_seq_chk.sv
module nand_strobe_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              nandCeN,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic              ioOe,
  input logic [DATA_W-1:0] ioOut,
  input logic              rdValid
);

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(nandCle && nandAle));

  p_strobe_in_ce_r2: assert property (@(posedge clk) disable iff (rst)
    (!nandReN || !nandWeN) |-> !nandCeN);

  p_accept_starts_r2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> ##1 !nandCeN);

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    !(!nandReN && !nandWeN));

  p_no_drive_read_r8: assert property (@(posedge clk) disable iff (rst)
    !nandReN |-> !ioOe);

  p_rd_on_release_r8: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> (nandReN && $past(!nandReN)));

  p_wr_byte_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !nandWeN |-> $stable(ioOut));

endmodule

bind nand_strobe_seq nand_strobe_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_nand_strobe_seq.sv
module sim_nand_strobe_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [1:0] reqKind = 2'd0;
  logic [7:0] reqByte = 8'd0;
  logic       rdValid;
  logic [7:0] rdByte;
  logic [7:0] cfgHiz = 0, cfgSetup = 0, cfgStrobe = 0, cfgHold = 0;
  logic [7:0] cfgCleRe = 0, cfgAleRe = 0;
  logic       cfgWaitEn = 1'b0;
  logic       rbN = 1'b1;
  logic       nandCeN, nandCle, nandAle, nandWeN, nandReN, ioOe;
  logic [7:0] ioOut;
  logic [7:0] ioIn = 8'h00;

  always #(CLK_PERIOD/2) clk = !clk;

  nand_strobe_seq u0 (.*);

  int checks = 0, errors = 0, cyc = 0;

  // per-transfer timestamps recorded at negedges
  int  tCeFall, tCeRise, tOeRise, tOeFall, tStFall, tStRise;
  int  lastCleFall = -100000, lastAleFall = -100000;
  int  cleAtRead, aleAtRead;
  bit  seenCle, seenAle, oeInRead, rdAtRise, doneFlag;
  logic [7:0] rdGot, wrSeen;
  logic pCeN = 1, pCle = 0, pAle = 0, pWeN = 1, pReN = 1, pOe = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst) begin
      if (pCeN && !nandCeN) begin
        tCeFall = cyc; seenCle = 0; seenAle = 0; oeInRead = 0; rdAtRise = 0;
      end
      if (!pCeN && nandCeN) begin tCeRise = cyc; doneFlag = 1; end
      if (nandCle) seenCle = 1;
      if (nandAle) seenAle = 1;
      if (pCle && !nandCle) lastCleFall = cyc;
      if (pAle && !nandAle) lastAleFall = cyc;
      if (!pOe && ioOe) tOeRise = cyc;
      if (pOe && !ioOe) tOeFall = cyc;
      if (pWeN && !nandWeN) begin tStFall = cyc; wrSeen = ioOut; end
      if (pReN && !nandReN) begin
        tStFall = cyc; cleAtRead = cyc - lastCleFall; aleAtRead = cyc - lastAleFall;
      end
      if ((!pWeN && nandWeN) || (!pReN && nandReN)) tStRise = cyc;
      if (!pReN && nandReN) begin rdAtRise = rdValid; rdGot = rdByte; end
      if (!nandReN && ioOe) oeInRead = 1;
      pCeN = nandCeN; pCle = nandCle; pAle = nandAle;
      pWeN = nandWeN; pReN = nandReN; pOe = ioOe;
    end
  end

  function automatic int expWidth(logic [7:0] s);
    return (s == 0) ? 1 : int'(s);
  endfunction

  task automatic runXfer(logic [1:0] kind, logic [7:0] b);
    logic [7:0] dev;
    dev = 8'($urandom);
    @(negedge clk);
    doneFlag = 0;
    reqKind = kind; reqByte = b; ioIn = dev; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!doneFlag) @(negedge clk);
    check(seenCle == (kind == 2'd0), "R2 command latch", int'(seenCle), int'(kind == 2'd0));
    check(seenAle == (kind == 2'd1), "R2 address latch", int'(seenAle), int'(kind == 2'd1));
    check(tStRise - tStFall == expWidth(cfgStrobe), "R5 strobe width",
          tStRise - tStFall, expWidth(cfgStrobe));
    check(tCeRise - tStRise == int'(cfgHold), "R6 hold", tCeRise - tStRise, int'(cfgHold));
    if (kind != 2'd3) begin
      check(tOeRise - tCeFall == int'(cfgHiz), "R3 undriven time",
            tOeRise - tCeFall, int'(cfgHiz));
      check(tStFall - tOeRise == int'(cfgSetup), "R4 write setup",
            tStFall - tOeRise, int'(cfgSetup));
      check(tOeFall == tCeRise, "R6 drive release", tOeFall, tCeRise);
      check(wrSeen == b, "R10 write byte", int'(wrSeen), int'(b));
    end else begin
      check(tStFall - tCeFall >= int'(cfgSetup) + 1, "R4 read setup",
            tStFall - tCeFall, int'(cfgSetup) + 1);
      check(cleAtRead >= int'(cfgCleRe), "R7 command-to-read delay", cleAtRead, int'(cfgCleRe));
      check(aleAtRead >= int'(cfgAleRe), "R7 address-to-read delay", aleAtRead, int'(cfgAleRe));
      check(!oeInRead, "R8 no drive in read", int'(oeInRead), 0);
      check(rdAtRise && rdGot == dev, "R8 read byte",
            rdAtRise ? int'(rdGot) : -1, int'(dev));
    end
    @(negedge clk);
  endtask

  task automatic setCfg(int hz, int su, int sb, int hd, int cr, int ar);
    cfgHiz = 8'(hz); cfgSetup = 8'(su); cfgStrobe = 8'(sb);
    cfgHold = 8'(hd); cfgCleRe = 8'(cr); cfgAleRe = 8'(ar);
  endtask

  initial begin
    bit ceStayedHigh;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(nandCeN && nandWeN && nandReN, "R1 strobes idle", {nandCeN, nandWeN, nandReN}, 7);
    check(!nandCle && !nandAle && !ioOe, "R1 latches low", {nandCle, nandAle, ioOe}, 0);
    check(reqReady && !rdValid, "R1 ready", {reqReady, rdValid}, 2);

    // zero timing, including zero hold with a read (capture and release together)
    setCfg(0, 0, 0, 0, 0, 0);
    runXfer(2'd0, 8'h70); runXfer(2'd1, 8'h12); runXfer(2'd2, 8'hA5); runXfer(2'd3, 8'h00);
    runXfer(2'd3, 8'h00);

    // long command/address to read delays (R7)
    setCfg(1, 0, 2, 0, 40, 25);
    runXfer(2'd0, 8'h00); runXfer(2'd3, 8'h00);
    runXfer(2'd1, 8'h33); runXfer(2'd3, 8'h00);

    // extreme counts
    setCfg(254, 254, 254, 254, 255, 255);
    runXfer(2'd2, 8'h5A); runXfer(2'd0, 8'hFF); runXfer(2'd3, 8'h00);

    // R9 busy holds off a transfer
    setCfg(2, 1, 1, 1, 0, 0);
    cfgWaitEn = 1'b1; rbN = 1'b0;
    repeat (4) @(negedge clk);
    reqKind = 2'd0; reqByte = 8'h90; reqValid = 1'b1;
    ceStayedHigh = 1;
    repeat (30) begin @(negedge clk); if (!nandCeN) ceStayedHigh = 0; end
    check(ceStayedHigh, "R9 busy blocks start", int'(ceStayedHigh), 1);
    check(!reqReady, "R9 not ready while busy", int'(reqReady), 0);
    reqValid = 1'b0;
    rbN = 1'b1;
    repeat (3) @(negedge clk);
    runXfer(2'd0, 8'h90);
    // R9 busy ignored when waiting disabled
    cfgWaitEn = 1'b0; rbN = 1'b0;
    repeat (4) @(negedge clk);
    runXfer(2'd1, 8'h44);
    check(tCeRise > tCeFall, "R9 busy ignored", tCeRise - tCeFall, 1);
    rbN = 1'b1;

    // constrained random rounds
    for (int r = 0; r < 40; r++) begin
      setCfg($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6),
             $urandom_range(0, 6), $urandom_range(0, 15), $urandom_range(0, 15));
      for (int k = 0; k < 6; k++) runXfer(2'($urandom_range(0, 3)), 8'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule